// File: doc/BRIEF.md
# Paged Palette Color Lookup

This block turns each pixel-port word into a 24-bit color. Every pixel clock it builds an 8-bit palette address. The low address bits come from the pixel port. The number of those bits depends on the plane mode. The remaining high bits come straight from the page register, bit for bit. The full address is then ANDed with a read mask, and the palette RAM is read through a two-stage registered pipeline.

Changing the page register therefore redirects every pixel to a different palette page without reloading the RAM.

A 5-5-5 direct-color mode is also provided. In that mode the pixel word carries one overlay bit and three 5-bit channels. When the page register is all zero and the overlay bit is clear, the channels bypass the RAM and appear on the output. In every other case the pixel goes through the palette.

A simple write port loads the palette RAM.

Top module: `pixel_palette_lookup`

## Requirements
- R1: With modeSel 0 (8 planes), or any unused code 5, 6 or 7, the lookup address is pixIn[7:0] AND readMask, and pageReg has no effect.
- R2: With modeSel 1 (4 planes), the lookup address is {pageReg[7:4], pixIn[3:0]} AND readMask.
- R3: With modeSel 2 (2 planes), the lookup address is {pageReg[7:2], pixIn[1:0]} AND readMask.
- R4: With modeSel 3 (1 plane), the lookup address is {pageReg[7:1], pixIn[0]} AND readMask.
- R5: The read mask is applied after the page bits are inserted, so a cleared mask bit forces that address bit to 0 whether it came from the page register or from the pixel.
- R6: With modeSel 4 (5-5-5), pageReg equal to 0 and overlay bit pixIn[15] equal to 0, colorOut is {pixIn[14:10],000, pixIn[9:5],000, pixIn[4:0],000}, with red in bits 23:16 and blue in bits 7:0.
- R7: With modeSel 4 and either pixIn[15] equal to 1 or pageReg nonzero, the palette entry at {pageReg[7:1], pixIn[15]} AND readMask is output.
- R8: A pixel sampled with pixValid high appears on colorOut with colorValid high exactly two clock edges later. colorValid is low two edges after an edge that sampled pixValid low.
- R9: A new pageReg value applies to the very next pixel sampled, including back-to-back pixels.
- R10: While rstN is low, colorValid and colorOut are 0.
- R11: A palette write (wrEn, wrAddr, wrData) is seen by any lookup sampled after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixValid | input | 1 | Pixel word valid this clock |
| pixIn | input | 16 | Pixel word: plane bits low; in 5-5-5 mode, bit 15 is the overlay bit |
| pageReg | input | 8 | Palette page bits |
| modeSel | input | 3 | 0: 8 planes, 1: 4, 2: 2, 3: 1, 4: 5-5-5 direct color |
| readMask | input | 8 | Address AND mask |
| wrEn | input | 1 | Palette write strobe |
| wrAddr | input | 8 | Palette write address |
| wrData | input | 24 | Palette write color |
| colorValid | output | 1 | colorOut holds a new result |
| colorOut | output | 24 | Looked-up or direct color |

## Verification
The bench walks each plane mode with page values whose bits differ from the pixel bits. A design that took the wrong page slice, or that let the page leak into 8-plane mode, returns an entry from the wrong palette page.

It applies a mask that clears both page bits and pixel bits, which exposes a mask applied before the page bits are inserted. It changes the page register on back-to-back pixels, which catches a stale or late-registered page. It covers the three 5-5-5 cases (page zero with the overlay bit clear, the overlay bit set, and a nonzero page), which catch a bad true-color enable test or a missing overlay fallback.

Every result is also timed against the two-edge latency.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int PAL_AW = 8;

  typedef enum logic [2:0] {
    MODE_P8 = 3'd0,
    MODE_P4 = 3'd1,
    MODE_P2 = 3'd2,
    MODE_P1 = 3'd3,
    MODE_TC = 3'd4
  } planeMode_e;

  typedef struct packed {
    logic              load1;
    logic              load2;
    logic              tcMode;
    logic              trueEn;
    logic [PAL_AW-1:0] pageFill;
  } ctrlStrobes_t;
endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palette_pkg::*;
#(
  parameter int AW = PAL_AW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pixValid,
  input  logic [AW-1:0] pageReg,
  input  logic [2:0]    modeSel,
  output ctrlStrobes_t  strb,
  output logic          colorValid
);
  int planeBits;
  logic [AW-1:0] fillBits;
  logic valid1, valid2;

  always_comb begin
    case (modeSel)
      MODE_P4: planeBits = 4;
      MODE_P2: planeBits = 2;
      MODE_P1: planeBits = 1;
      MODE_TC: planeBits = 1;
      default: planeBits = AW;
    endcase
  end

  for (genvar g = 0; g < AW; g++) begin : g_fill
    assign fillBits[g] = (g >= planeBits);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid1 <= 1'b0;
      valid2 <= 1'b0;
    end else begin
      valid1 <= pixValid;
      valid2 <= valid1;
    end
  end

  always_comb begin
    strb.load1    = pixValid;
    strb.load2    = valid1;
    strb.tcMode   = (modeSel == MODE_TC);
    strb.trueEn   = (modeSel == MODE_TC) && (pageReg == '0);
    strb.pageFill = fillBits;
  end

  assign colorValid = valid2;
endmodule

// File: rtl/palette_datapath.sv
module palette_datapath
  import palette_pkg::*;
#(
  parameter int AW = PAL_AW,
  parameter int PW = 16,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strb,
  input  logic [PW-1:0] pixIn,
  input  logic [AW-1:0] pageReg,
  input  logic [AW-1:0] readMask,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [CW-1:0] wrData,
  output logic [AW-1:0] lookupAddr,
  output logic [CW-1:0] colorOut
);
  localparam int DEPTH = 1 << AW;
  localparam int CH    = CW / 3;

  logic [CW-1:0] palMem [DEPTH];
  logic [AW-1:0] pixLow, formedAddr, maskedAddr, addrQ;
  logic [CW-1:0] directColor, direct1Q, direct2Q, ramQ;
  logic          bypass1Q, bypass2Q;

  always_comb begin
    pixLow     = strb.tcMode ? {{(AW-1){1'b0}}, pixIn[PW-1]} : pixIn[AW-1:0];
    formedAddr = (pageReg & strb.pageFill) | (pixLow & ~strb.pageFill);
    maskedAddr = formedAddr & readMask;
  end

  for (genvar g = 0; g < 3; g++) begin : g_chan
    assign directColor[g*CH +: CH] = {pixIn[g*5 +: 5], {(CH-5){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (wrEn) palMem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      bypass1Q <= 1'b0;
      direct1Q <= '0;
    end else if (strb.load1) begin
      addrQ    <= maskedAddr;
      bypass1Q <= strb.trueEn && !pixIn[PW-1];
      direct1Q <= directColor;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramQ     <= '0;
      bypass2Q <= 1'b0;
      direct2Q <= '0;
    end else if (strb.load2) begin
      ramQ     <= palMem[addrQ];
      bypass2Q <= bypass1Q;
      direct2Q <= direct1Q;
    end
  end

  assign lookupAddr = addrQ;
  assign colorOut   = bypass2Q ? direct2Q : ramQ;
endmodule

// File: rtl/pixel_palette_lookup.sv
module pixel_palette_lookup
  import palette_pkg::*;
#(
  parameter int AW = PAL_AW,
  parameter int PW = 16,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pixValid,
  input  logic [PW-1:0] pixIn,
  input  logic [AW-1:0] pageReg,
  input  logic [2:0]    modeSel,
  input  logic [AW-1:0] readMask,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [CW-1:0] wrData,
  output logic          colorValid,
  output logic [CW-1:0] colorOut
);
  ctrlStrobes_t  strb;
  logic [AW-1:0] lookupAddr;

  palette_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pageReg(pageReg),
    .modeSel(modeSel), .strb(strb), .colorValid(colorValid)
  );

  palette_datapath #(.AW(AW), .PW(PW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pixIn(pixIn), .pageReg(pageReg),
    .readMask(readMask), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lookupAddr(lookupAddr), .colorOut(colorOut)
  );
endmodule

// File: rtl/palette_chk.sv
module palette_chk #(
  parameter int AW = 8,
  parameter int PW = 16,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          pixValid,
  input logic [PW-1:0] pixIn,
  input logic [AW-1:0] pageReg,
  input logic [2:0]    modeSel,
  input logic [AW-1:0] readMask,
  input logic          colorValid,
  input logic [CW-1:0] colorOut,
  input logic [AW-1:0] addrQ
);
  localparam int CH = CW / 3;

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |-> (!colorValid && colorOut == '0));

  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> ##1 colorValid);

  // R8
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> ##1 !colorValid);

  // R5
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> ((addrQ & ~$past(readMask)) == '0));

  // R2
  plane4_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && modeSel == 3'd1) |=>
      (addrQ == ({$past(pageReg[AW-1:AW-4]), $past(pixIn[3:0])} & $past(readMask))));

  // R6
  direct_color_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && modeSel == 3'd4 && pageReg == '0 && !pixIn[PW-1]) |=> ##1
      (colorOut == {$past(pixIn[14:10], 2), {(CH-5){1'b0}},
                    $past(pixIn[9:5], 2),   {(CH-5){1'b0}},
                    $past(pixIn[4:0], 2),   {(CH-5){1'b0}}}));
endmodule

bind pixel_palette_lookup palette_chk #(.AW(AW), .PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixIn(pixIn), .pageReg(pageReg),
  .modeSel(modeSel), .readMask(readMask), .colorValid(colorValid),
  .colorOut(colorOut), .addrQ(lookupAddr)
);

// File: tb/test_pixel_palette_lookup.sv
module test_pixel_palette_lookup;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixValid = 1'b0;
  logic [15:0] pixIn = '0;
  logic [7:0]  pageReg = '0;
  logic [2:0]  modeSel = '0;
  logic [7:0]  readMask = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [23:0] wrData = '0;
  logic        colorValid;
  logic [23:0] colorOut;

  pixel_palette_lookup i_pixel_palette_lookup (.*);

  always #4 clk = ~clk;

  typedef struct {
    logic [23:0] c;
    string       req;
    int          cyc;
  } item_t;

  item_t       sb[$];
  logic [23:0] shadow [256];
  int          cycleCnt = 0;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  function automatic logic [23:0] palInit(input logic [7:0] a);
    return {a, a ^ 8'hFF, a + 8'h37};
  endfunction

  function automatic logic [23:0] expColor(input logic [15:0] p, input logic [7:0] pg,
                                           input logic [2:0] m, input logic [7:0] mk);
    logic [7:0] fill, low, addr;
    case (m)
      3'd1:       fill = 8'hF0;
      3'd2:       fill = 8'hFC;
      3'd3, 3'd4: fill = 8'hFE;
      default:    fill = 8'h00;
    endcase
    low  = (m == 3'd4) ? {7'b0, p[15]} : p[7:0];
    addr = ((pg & fill) | (low & ~fill)) & mk;
    if (m == 3'd4 && pg == 8'h00 && !p[15])
      return {p[14:10], 3'b0, p[9:5], 3'b0, p[4:0], 3'b0};
    return shadow[addr];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendPix(input logic [15:0] p, input logic [7:0] pg, input logic [2:0] m,
                         input logic [7:0] mk, input string req);
    item_t it;
    @(negedge clk);
    pixValid = 1'b1; pixIn = p; pageReg = pg; modeSel = m; readMask = mk;
    it.c = expColor(p, pg, m, mk);
    it.req = req;
    it.cyc = cycleCnt;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pixValid = 1'b0;
    end
  endtask

  task automatic palWrite(input logic [7:0] a, input logic [23:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    shadow[a] = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rstN && !done && colorValid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected colorValid", 32'(colorValid), 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(colorOut == it.c, it.req, 32'(colorOut), 32'(it.c));
        check(cycleCnt == it.cyc + 2, "R8 latency", 32'(cycleCnt - it.cyc), 2);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 outputs held idle in reset
    check(!colorValid && colorOut == '0, "R10 reset", {7'b0, colorValid, colorOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!colorValid, "R10 after reset", 32'(colorValid), 0);

    for (int a = 0; a < 256; a++) palWrite(8'(a), palInit(8'(a)));

    // R1 eight planes: page ignored, unused codes act alike
    sendPix(16'h0012, 8'hFF, 3'd0, 8'hFF, "R1 p8 a");
    sendPix(16'h00C7, 8'h5A, 3'd0, 8'hFF, "R1 p8 b");
    sendPix(16'h0081, 8'h00, 3'd5, 8'hFF, "R1 code5");
    sendPix(16'h0033, 8'hA0, 3'd7, 8'hFF, "R1 code7");
    idle(3);
    // R2 R3 R4 page slices
    sendPix(16'h00FB, 8'hA5, 3'd1, 8'hFF, "R2 p4 a");
    sendPix(16'h0003, 8'h3C, 3'd1, 8'hFF, "R2 p4 b");
    sendPix(16'h00FE, 8'h55, 3'd2, 8'hFF, "R3 p2 a");
    sendPix(16'h0001, 8'hA8, 3'd2, 8'hFF, "R3 p2 b");
    sendPix(16'h00F0, 8'h6D, 3'd3, 8'hFF, "R4 p1 a");
    sendPix(16'h0001, 8'h92, 3'd3, 8'hFF, "R4 p1 b");
    idle(2);
    // R5 mask over page and pixel bits
    sendPix(16'h000F, 8'hF0, 3'd1, 8'h3C, "R5 mask p4");
    sendPix(16'h00FF, 8'h00, 3'd0, 8'h81, "R5 mask p8");
    sendPix(16'h0001, 8'hFE, 3'd3, 8'h0F, "R5 mask p1");
    idle(2);
    // R9 page change on back-to-back pixels
    sendPix(16'h0009, 8'h10, 3'd1, 8'hFF, "R9 page 1");
    sendPix(16'h0009, 8'h20, 3'd1, 8'hFF, "R9 page 2");
    sendPix(16'h0009, 8'hE0, 3'd1, 8'hFF, "R9 page 3");
    sendPix(16'h0009, 8'h00, 3'd1, 8'hFF, "R9 page 4");
    idle(3);
    // R6 direct color
    sendPix(16'h7FFF, 8'h00, 3'd4, 8'hFF, "R6 tc white");
    sendPix(16'h4C21, 8'h00, 3'd4, 8'h00, "R6 tc mask ignored");
    sendPix(16'h0000, 8'h00, 3'd4, 8'hFF, "R6 tc black");
    // R7 overlay or nonzero page falls back to palette
    sendPix(16'h8123, 8'h00, 3'd4, 8'hFF, "R7 overlay set");
    sendPix(16'h0123, 8'h01, 3'd4, 8'hFF, "R7 page nonzero");
    sendPix(16'h8456, 8'hB6, 3'd4, 8'hFF, "R7 page and overlay");
    sendPix(16'h8456, 8'hB6, 3'd4, 8'h71, "R7 masked");
    idle(3);
    // R11 rewritten entry seen by later lookup
    palWrite(8'h42, 24'hC0FFEE);
    sendPix(16'h0042, 8'h00, 3'd0, 8'hFF, "R11 rewrite");
    idle(4);
    check(sb.size() == 0, "R8 drained", 32'(sb.size()), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule